// File: doc/BRIEF.md
# Three-Phase Reverse Power Flag

This block raises one flag when real power flows backwards on any of three phases. A reversal happens when the load exports energy, or when a meter is wired wrongly so that the angle between a phase's voltage and current exceeds 90 degrees. Each phase delivers signed instantaneous power samples under a shared valid strobe. Between two pulses of the calibration-frequency strobe, the block sums those samples in one saturating signed accumulator per phase.

On each calibration pulse, every phase takes a new sign decision from its sum and its accumulator restarts from zero. A negative sum marks the phase as reversed. A positive sum clears the mark. A sum of exactly zero leaves the earlier decision in place. The output is the OR of the three marks. It is not latched: it falls by itself once every phase reads positive again. It can only move on a calibration pulse, so the flag stays aligned with the pulses that an external counter sees.

Top module: `rev_power_flag`

## Requirements
- R1: While `rst_ni` is low, `rev_flag_o` is 0 and all three accumulators are zero. A calibration pulse that arrives after reset with no samples in between leaves the flag at 0.
- R2: A phase sample is added to its accumulator only in a cycle where `smp_vld_i` is 1. Samples presented while `smp_vld_i` is 0 have no effect on any later decision.
- R3: On a clock edge with `cf_pulse_i` high, a phase whose interval sum is negative (sign bit 1, nonzero) is marked reversed. From that edge, `rev_flag_o` is 1 if any phase is marked.
- R4: On a calibration edge at which all three interval sums are positive, `rev_flag_o` becomes 0.
- R5: A phase whose interval sum is exactly zero at a calibration edge keeps the mark it had before.
- R6: `rev_flag_o` changes only at a clock edge where `cf_pulse_i` is high, and holds its value at every other edge.
- R7: Each accumulator restarts from zero after every calibration edge, so each interval's decision depends only on the samples of that interval.
- R8: A valid sample presented in the same cycle as the calibration pulse belongs to the interval that this pulse closes.
- R9: Each accumulator is ACC_W = PWR_W + ACC_EXT bits wide and saturates at its signed limits instead of wrapping. A long run of samples of one sign therefore never flips the decided sign.
- R10: The flag is not latched. After a reversal, an interval in which every phase sums positive returns it to 0 with no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Qualifies the three power samples this cycle |
| pwr_a_i | input | PWR_W | Signed power sample, phase A |
| pwr_b_i | input | PWR_W | Signed power sample, phase B |
| pwr_c_i | input | PWR_W | Signed power sample, phase C |
| cf_pulse_i | input | 1 | Single-cycle calibration pulse strobe |
| rev_flag_o | output | 1 | Reverse power flag, high while any phase is marked reversed |

## Verification
The sign decisions and the flag are registered on the edge at which `cf_pulse_i` is seen high, so the flag is due one edge after that pulse and must be unchanged after every other edge. The bench drives all inputs on the falling edge. It applies each cycle's stimulus to its own model at the following rising edge and compares the flag at the next falling edge. In this way every check samples exactly one edge after its stimulus, including the cycles without a pulse where the flag must hold.

// File: rtl/rpi_pkg.sv
package rpi_pkg;
  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } sgn_e;
endpackage

// File: rtl/rpi_sat_add.sv
module rpi_sat_add #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W:0] ext_w;

  assign ext_w = {a_i[W-1], a_i} + {b_i[W-1], b_i};

  always_comb begin
    if (ext_w[W] != ext_w[W-1]) begin
      // overflow: clamp toward the true sign
      s_o = ext_w[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      s_o = ext_w[W-1:0];
    end
  end
endmodule

// File: rtl/rpi_phase_acc.sv
module rpi_phase_acc
  import rpi_pkg::*;
#(
  parameter int PWR_W = 16,
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [PWR_W-1:0] smp_i,
  input  logic             cf_i,
  output logic             pos_o,
  output logic             neg_o,
  output logic             neg_q_o
);
  localparam int EXT_W = ACC_W - PWR_W;

  logic [ACC_W-1:0] acc_q, add_w, sum_w;
  sgn_e             sgn_w;
  logic             neg_q;

  assign add_w = vld_i ? {{EXT_W{smp_i[PWR_W-1]}}, smp_i} : '0;

  rpi_sat_add #(.W(ACC_W)) u_add (
    .a_i (acc_q),
    .b_i (add_w),
    .s_o (sum_w)
  );

  always_comb begin
    if (sum_w == '0)          sgn_w = SGN_ZERO;
    else if (sum_w[ACC_W-1])  sgn_w = SGN_NEG;
    else                      sgn_w = SGN_POS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      neg_q <= 1'b0;
    end else if (cf_i) begin
      acc_q <= '0;
      if (sgn_w == SGN_NEG)      neg_q <= 1'b1;
      else if (sgn_w == SGN_POS) neg_q <= 1'b0;
    end else begin
      acc_q <= sum_w;
    end
  end

  assign pos_o   = (sgn_w == SGN_POS);
  assign neg_o   = (sgn_w == SGN_NEG);
  assign neg_q_o = neg_q;
endmodule

// File: rtl/rev_power_flag.sv
module rev_power_flag #(
  parameter int PWR_W   = 16,
  parameter int ACC_EXT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [PWR_W-1:0] pwr_a_i,
  input  logic [PWR_W-1:0] pwr_b_i,
  input  logic [PWR_W-1:0] pwr_c_i,
  input  logic             cf_pulse_i,
  output logic             rev_flag_o
);
  localparam int ACC_W = PWR_W + ACC_EXT;
  localparam int NPH   = 3;

  logic [PWR_W-1:0] smp_w [NPH];
  logic [NPH-1:0]   pos_w, negv_w, neg_q;

  assign smp_w[0] = pwr_a_i;
  assign smp_w[1] = pwr_b_i;
  assign smp_w[2] = pwr_c_i;

  for (genvar g = 0; g < NPH; g++) begin : gen_ph
    rpi_phase_acc #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_ph (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_i   (smp_vld_i),
      .smp_i   (smp_w[g]),
      .cf_i    (cf_pulse_i),
      .pos_o   (pos_w[g]),
      .neg_o   (negv_w[g]),
      .neg_q_o (neg_q[g])
    );
  end

  assign rev_flag_o = |neg_q;
endmodule

// File: rtl/rpi_chk.sv
module rpi_chk #(
  parameter int NPH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cf_pulse_i,
  input logic           rev_flag_o,
  input logic [NPH-1:0] pos_w,
  input logic [NPH-1:0] negv_w,
  input logic [NPH-1:0] neg_q
);
  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !rev_flag_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cf_pulse_i |=> $stable(rev_flag_o));

  // R3
  any_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_pulse_i && (negv_w != '0)) |=> rev_flag_o);

  // R4
  all_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_pulse_i && (&pos_w)) |=> !rev_flag_o);

  // R5
  zero_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_pulse_i |=> (((neg_q ^ $past(neg_q)) & ~$past(pos_w | negv_w)) == '0));
endmodule

bind rev_power_flag rpi_chk #(.NPH(3)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cf_pulse_i (cf_pulse_i),
  .rev_flag_o (rev_flag_o),
  .pos_w      (pos_w),
  .negv_w     (negv_w),
  .neg_q      (neg_q)
);

// File: tb/rev_power_flag_bench.sv
module rev_power_flag_bench;
  localparam int PWR_W = 16;
  localparam int ACC_W = 24;
  localparam longint SMAX = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (ACC_W-1));

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_vld_i = 1'b0;
  logic [PWR_W-1:0] pwr_a_i = '0, pwr_b_i = '0, pwr_c_i = '0;
  logic cf_pulse_i = 1'b0;
  logic rev_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint m_acc [3];
  bit     m_neg [3];

  always #5 clk_i = ~clk_i;

  rev_power_flag #(.PWR_W(PWR_W), .ACC_EXT(ACC_W-PWR_W)) u_rev_power_flag (
    .clk_i, .rst_ni, .smp_vld_i, .pwr_a_i, .pwr_b_i, .pwr_c_i,
    .cf_pulse_i, .rev_flag_o
  );

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic bit m_flag();
    return m_neg[0] | m_neg[1] | m_neg[2];
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (rev_flag_o !== exp) begin
      errors++;
      $display("FAIL %s: rev_flag_o=%b expected=%b at %0t", req, rev_flag_o, exp, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit vld, input int a, input int b, input int c,
                     input bit cf, input string tag);
    int s [3];
    s[0] = a; s[1] = b; s[2] = c;
    smp_vld_i  = vld;
    pwr_a_i    = PWR_W'(a);
    pwr_b_i    = PWR_W'(b);
    pwr_c_i    = PWR_W'(c);
    cf_pulse_i = cf;
    @(posedge clk_i);
    for (int i = 0; i < 3; i++) begin
      longint t;
      t = vld ? sat(m_acc[i] + longint'(s[i])) : m_acc[i];
      if (cf) begin
        if (t < 0) m_neg[i] = 1'b1;
        else if (t > 0) m_neg[i] = 1'b0;
        m_acc[i] = 0;
      end else begin
        m_acc[i] = t;
      end
    end
    @(negedge clk_i);
    smp_vld_i  = 1'b0;
    cf_pulse_i = 1'b0;
    check(cf ? tag : "R6", m_flag());
  endtask

  initial begin
    void'($urandom(32'd1729));
    for (int i = 0; i < 3; i++) begin m_acc[i] = 0; m_neg[i] = 0; end
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 1'b0);
    cyc(0, 0, 0, 0, 1, "R1");
    // all positive
    cyc(1, 100, 200, 300, 0, "R4");
    cyc(1, -50, 10, 5, 0, "R4");
    cyc(0, 0, 0, 0, 1, "R4");
    // phase B reversed
    cyc(1, 40, -90, 40, 0, "R3");
    cyc(1, 40, -90, 40, 0, "R3");
    cyc(0, 0, 0, 0, 1, "R3");
    // B sums to zero: keeps its mark
    cyc(1, 10, 7, 10, 0, "R5");
    cyc(1, 10, -7, 10, 0, "R5");
    cyc(0, 0, 0, 0, 1, "R5");
    // all positive again: flag clears itself
    cyc(1, 10, 20, 30, 0, "R10");
    cyc(0, 0, 0, 0, 1, "R10");
    // samples without valid are ignored
    cyc(0, -30000, -30000, -30000, 0, "R2");
    cyc(0, -30000, -30000, -30000, 0, "R2");
    cyc(0, -30000, -30000, -30000, 1, "R2");
    // interval independence
    cyc(1, 1000, 1000, 1000, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R7");
    cyc(1, 5, 5, -1, 0, "R7");
    cyc(0, 0, 0, 0, 1, "R7");
    // sample on the pulse cycle closes the interval
    cyc(1, 3, 3, 3, 0, "R8");
    cyc(1, -10, 3, 3, 1, "R8");
    cyc(1, 5, 5, 5, 1, "R8");
    // saturation keeps the sign (wrapping would read positive)
    for (int k = 0; k < 300; k++) cyc(1, -32768, 1, 1, 0, "R9");
    cyc(0, 0, 0, 0, 1, "R9");
    cyc(1, 9, 9, 9, 1, "R9");
    // random intervals
    for (int n = 0; n < 60; n++) begin
      int len;
      int bias [3];
      len = int'($urandom_range(1, 20));
      for (int i = 0; i < 3; i++) bias[i] = (int'($urandom_range(0, 2)) - 1) * 300;
      for (int k = 0; k < len; k++) begin
        cyc(bit'($urandom_range(0, 3) != 0),
            int'($urandom_range(0, 2000)) - 1000 + bias[0],
            int'($urandom_range(0, 2000)) - 1000 + bias[1],
            int'($urandom_range(0, 2000)) - 1000 + bias[2],
            k == len - 1, "R3");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: rev_flag_o=%b expected=finish", rev_flag_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule